// File: doc/BRIEF.md
# Amplifier Power-Stage Enable Sequencer

This block decides, cycle by cycle, whether a switching audio power stage may run. It watches a shutdown control, an external mute request, two supply-good flags (one for the digital supply, one for the power supply) and a protection fault flag. From these it drives a single enable for the power stage and a status bit that reports the mandatory internal mute window.

After shutdown is released, the block holds the stage off for a fixed number of master-clock cycles. The internal window ignores any early release of the external mute. Once the window has run out, the external mute is clear and both supplies are good, a short fixed settling delay must run before the stage is enabled. Any supply dropping out, or a new mute request, takes the enable away at once. When the supply returns or the mute clears, the stage comes back through the settling delay only. A fault switches the stage off and keeps it off until shutdown is cycled.

The mute, supply and fault flags enter through two-flop synchronizers. Shutdown is taken as a synchronous input. Both window lengths are parameters. The defaults match a 24.576 MHz master clock: 15,974,400 cycles for the mute window and 4,915 cycles for the settling delay.

Top module: `amp_stage_seq`

## Requirements
- R1: While reset is held and on the first sampled cycle after it, `stage_en` and `int_mute` are 0.
- R2: `int_mute` rises one edge after `shdn_n` is seen high and stays high for exactly IMUTE_CYCLES cycles. It is 1 at edge IMUTE_CYCLES and 0 at edge IMUTE_CYCLES+1, counted from the release.
- R3: An external unmute (`mute_ext`=0) given before the internal window ends does not enable the stage early. With mute clear and supplies good from the release, `stage_en` is 0 through edge IMUTE_CYCLES+SETTLE_CYCLES+1 and 1 at edge IMUTE_CYCLES+SETTLE_CYCLES+2.
- R4: When `mute_ext` is released after the internal window has ended, `stage_en` is 0 for SETTLE_CYCLES+2 edges and becomes 1 at edge SETTLE_CYCLES+3.
- R5: If either `dvdd_ok` or `pvdd_ok` is 0, the stage is held off even when the other flag is 1. A drop of either flag while running clears `stage_en` two edges later.
- R6: When a lost supply flag returns, `stage_en` comes back SETTLE_CYCLES+3 edges later, and `int_mute` stays 0 throughout.
- R7: `fault`=1 clears `stage_en` two edges later. The off state is latched: clearing `fault` or toggling `mute_ext` does not re-enable the stage. Only a shutdown cycle does.
- R8: `shdn_n`=0 clears `stage_en` and `int_mute` within one edge and resets both counters. The next release runs the full internal window again.
- R9: Asserting `mute_ext` while the stage runs clears `stage_en` two edges later. This is the orderly power-down path.
- R10: `stage_en` and `int_mute` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shdn_n | input | 1 | Shutdown control, 0 = shut down, 1 = released |
| mute_ext | input | 1 | External mute request, 1 = muted |
| dvdd_ok | input | 1 | Digital supply good, 1 = above threshold |
| pvdd_ok | input | 1 | Power supply good, 1 = above threshold |
| fault | input | 1 | Protection fault, 1 = fault present |
| stage_en | output | 1 | Power stage switching enable |
| int_mute | output | 1 | Internal mute window in progress |

## Verification
Each result has a fixed latency. A flag change reaches the enable gate after the two synchronizer edges. A state move needs one more edge, and the settling counter adds SETTLE_CYCLES. The mute window therefore ends at edge IMUTE_CYCLES+1 after release, enable follows at IMUTE_CYCLES+SETTLE_CYCLES+2, a late unmute or supply return enables at SETTLE_CYCLES+3, and a fault, mute or supply loss removes the enable at edge 2. The bench drives every input on a falling edge. It counts rising edges explicitly and samples a quarter period after the counted edge, checking both the last edge before each change and the edge where it must appear.

// File: rtl/amp_seq_pkg.sv
// Shared types for the amplifier power-stage enable sequencer.
package amp_seq_pkg;

    // Control states of the enable sequencer.
    typedef enum logic [2:0] {
        ST_SHUT  = 3'd0,   // shutdown held
        ST_IMUTE = 3'd1,   // fixed internal mute window counting
        ST_HOLD  = 3'd2,   // window over, waiting for unmute and supplies
        ST_DELAY = 3'd3,   // settling delay before switching
        ST_RUN   = 3'd4,   // stage switching
        ST_FAULT = 3'd5    // latched off after a fault
    } seq_state_t;

endpackage

// File: rtl/amp_seq_sync.sv
// Multi-flop synchronizer for one asynchronous level flag.
// Assumes STAGES >= 2; RST_VAL is the safe level loaded at reset.
module amp_seq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/amp_seq_counter.sv
// Interval counter: counts while run is high, clears while it is low.
// done is high in the last cycle of a LIMIT-cycle window (LIMIT >= 1).
module amp_seq_counter #(
    parameter int LIMIT = 4915
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    // Advance while running, restart whenever run drops.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    assign done = run && (cnt_q == LAST);

    // R2: the count never passes the last value of its window
    cnt_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/amp_seq_fsm.sv
// Control state machine of the sequencer. All flags arrive synchronized
// except shdn_n, which is assumed synchronous to clk. Counter done pulses
// come from separate interval counters driven by imute_run / delay_run.
module amp_seq_fsm
    import amp_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       shdn_n,
    input  logic       mute_s,
    input  logic       sup_ok_s,
    input  logic       fault_s,
    input  logic       imute_done,
    input  logic       delay_done,
    output logic       imute_run,
    output logic       delay_run,
    output logic       stage_en,
    output logic       int_mute
);
    seq_state_t state_q, state_d;
    logic       blocked;

    assign blocked = mute_s || !sup_ok_s;

    // Next-state selection; shutdown and fault take priority over the flow.
    always_comb begin
        state_d = state_q;
        if (!shdn_n) begin
            state_d = ST_SHUT;
        end else if (fault_s) begin
            state_d = ST_FAULT;
        end else begin
            case (state_q)
                ST_SHUT:  state_d = ST_IMUTE;
                ST_IMUTE: if (imute_done) state_d = ST_HOLD;
                ST_HOLD:  if (!blocked) state_d = ST_DELAY;
                ST_DELAY: begin
                    if (blocked)         state_d = ST_HOLD;
                    else if (delay_done) state_d = ST_RUN;
                end
                ST_RUN:   if (blocked) state_d = ST_HOLD;
                ST_FAULT: state_d = ST_FAULT;
                default:  state_d = ST_SHUT;
            endcase
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SHUT;
        else        state_q <= state_d;
    end

    assign imute_run = (state_q == ST_IMUTE);
    assign delay_run = (state_q == ST_DELAY);
    assign int_mute  = (state_q == ST_IMUTE);
    // Enable drops as soon as any blocking flag is seen, before the state moves.
    assign stage_en  = (state_q == ST_RUN) && shdn_n && !blocked && !fault_s;

    // R8
    shdn_forces_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n |=> (state_q == ST_SHUT));

    // R7
    fault_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAULT) && shdn_n |=> (state_q == ST_FAULT));

    // R2
    imute_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IMUTE) && shdn_n && !fault_s && !imute_done
        |=> (state_q == ST_IMUTE));

    // R3
    run_via_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_DELAY) && (state_q != ST_RUN) |=> (state_q != ST_RUN));
endmodule

// File: rtl/amp_stage_seq.sv
// Top of the amplifier power-stage enable sequencer. Synchronizes the mute,
// supply and fault flags, runs the internal mute window and the settling
// delay as parameterized cycle counts, and gates the power-stage enable.
module amp_stage_seq #(
    parameter int IMUTE_CYCLES  = 15974400,
    parameter int SETTLE_CYCLES = 4915,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shdn_n,
    input  logic mute_ext,
    input  logic dvdd_ok,
    input  logic pvdd_ok,
    input  logic fault,
    output logic stage_en,
    output logic int_mute
);
    localparam int NFLAG = 4;
    // Safe reset levels: muted, supplies bad, no fault. Bit order: mute, dvdd, pvdd, fault.
    localparam logic [NFLAG-1:0] FLAG_RST = 4'b0001;

    logic [NFLAG-1:0] flag_raw, flag_s;
    logic imute_run, delay_run, imute_done, delay_done;
    logic dvdd_s, pvdd_s;

    assign flag_raw = {fault, pvdd_ok, dvdd_ok, mute_ext};

    // One synchronizer per incoming flag.
    for (genvar i = 0; i < NFLAG; i++) begin : g_sync
        amp_seq_sync #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL (FLAG_RST[i])
        ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (flag_raw[i]),
            .q     (flag_s[i])
        );
    end

    assign dvdd_s = flag_s[1];
    assign pvdd_s = flag_s[2];

    amp_seq_counter #(.LIMIT(IMUTE_CYCLES)) u_imute_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (imute_run),
        .done  (imute_done)
    );

    amp_seq_counter #(.LIMIT(SETTLE_CYCLES)) u_settle_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (delay_run),
        .done  (delay_done)
    );

    amp_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .shdn_n     (shdn_n),
        .mute_s     (flag_s[0]),
        .sup_ok_s   (dvdd_s && pvdd_s),
        .fault_s    (flag_s[3]),
        .imute_done (imute_done),
        .delay_done (delay_done),
        .imute_run  (imute_run),
        .delay_run  (delay_run),
        .stage_en   (stage_en),
        .int_mute   (int_mute)
    );

    // R10
    mute_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(stage_en && int_mute));

    // R5
    supply_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dvdd_s && pvdd_s) |-> !stage_en);
endmodule

// File: tb/tb_amp_stage_seq.sv
module tb_amp_stage_seq;
    localparam int N = 40;   // internal mute window
    localparam int P = 5;    // settling delay

    logic clk = 1'b0;
    logic rst_n, shdn_n, mute_ext, dvdd_ok, pvdd_ok, fault;
    logic stage_en, int_mute;
    int   n_chk = 0, n_err = 0, excl_bad = 0;

    amp_stage_seq #(.IMUTE_CYCLES(N), .SETTLE_CYCLES(P), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .mute_ext(mute_ext),
        .dvdd_ok(dvdd_ok), .pvdd_ok(pvdd_ok), .fault(fault),
        .stage_en(stage_en), .int_mute(int_mute)
    );

    always #10 clk = ~clk;

    // Watch R10 on every falling edge.
    always @(negedge clk) if (rst_n && stage_en && int_mute) excl_bad++;

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // Wait n rising edges, then sample a quarter period later.
    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    // Shutdown with clean inputs, then release; stage must be running at the end.
    task automatic bring_up(input string req);
        @(negedge clk);
        shdn_n = 0; mute_ext = 0; dvdd_ok = 1; pvdd_ok = 1; fault = 0;
        edges(3);
        @(negedge clk); shdn_n = 1;
        edges(N);
        chk("R2", "int_mute at last window edge", int_mute, 1'b1);
        edges(1);
        chk("R2", "int_mute after window", int_mute, 1'b0);
        edges(P);
        chk(req, "stage_en one edge early", stage_en, 1'b0);
        edges(1);
        chk(req, "stage_en on time", stage_en, 1'b1);
    endtask

    task automatic t_reset();
        rst_n = 0; shdn_n = 1; mute_ext = 0; dvdd_ok = 1; pvdd_ok = 1; fault = 0;
        edges(3);
        chk("R1", "stage_en in reset", stage_en, 1'b0);
        chk("R1", "int_mute in reset", int_mute, 1'b0);
        @(negedge clk); rst_n = 1; shdn_n = 0;
        edges(1);
        chk("R1", "stage_en after reset", stage_en, 1'b0);
        chk("R1", "int_mute after reset", int_mute, 1'b0);
    endtask

    // R3: unmute present before the window ends does not shorten it.
    task automatic t_early_unmute();
        bring_up("R3");
    endtask

    // R4: late unmute after the window enables through the settling delay.
    task automatic t_late_unmute();
        @(negedge clk);
        shdn_n = 0; mute_ext = 1; dvdd_ok = 1; pvdd_ok = 1; fault = 0;
        edges(3);
        @(negedge clk); shdn_n = 1;
        edges(N + P + 6);
        chk("R4", "still muted", stage_en, 1'b0);
        @(negedge clk); mute_ext = 0;
        edges(P + 2);
        chk("R4", "stage_en before settle end", stage_en, 1'b0);
        edges(1);
        chk("R4", "stage_en after settle", stage_en, 1'b1);
    endtask

    // R5 / R6: supply loss while running and its return.
    task automatic t_supply_run();
        bring_up("R3");
        @(negedge clk); pvdd_ok = 0;
        edges(1);
        chk("R5", "enable before sync delay", stage_en, 1'b1);
        edges(1);
        chk("R5", "pvdd loss drops enable", stage_en, 1'b0);
        edges(5);
        @(negedge clk); pvdd_ok = 1;
        edges(P + 2);
        chk("R6", "enable before settle end", stage_en, 1'b0);
        chk("R6", "no new window", int_mute, 1'b0);
        edges(1);
        chk("R6", "enable back after settle", stage_en, 1'b1);
        @(negedge clk); dvdd_ok = 0;
        edges(2);
        chk("R5", "dvdd loss drops enable", stage_en, 1'b0);
        @(negedge clk); dvdd_ok = 1;
        edges(P + 3);
        chk("R6", "enable back after dvdd return", stage_en, 1'b1);
    endtask

    // R5: one supply bad at start-up keeps the stage off.
    task automatic t_supply_start();
        @(negedge clk);
        shdn_n = 0; mute_ext = 0; dvdd_ok = 1; pvdd_ok = 0; fault = 0;
        edges(3);
        @(negedge clk); shdn_n = 1;
        edges(N + P + 10);
        chk("R5", "pvdd bad holds off", stage_en, 1'b0);
        @(negedge clk); pvdd_ok = 1;
        edges(P + 3);
        chk("R5", "enable once pvdd good", stage_en, 1'b1);
    endtask

    // R7: fault latch, cleared only by a shutdown cycle.
    task automatic t_fault();
        bring_up("R3");
        @(negedge clk); fault = 1;
        edges(2);
        chk("R7", "fault drops enable", stage_en, 1'b0);
        @(negedge clk); fault = 0;
        edges(P + 10);
        chk("R7", "latched after fault clears", stage_en, 1'b0);
        @(negedge clk); mute_ext = 1;
        edges(4);
        @(negedge clk); mute_ext = 0;
        edges(P + 10);
        chk("R7", "latched after mute toggle", stage_en, 1'b0);
        bring_up("R7");
    endtask

    // R8: shutdown mid-window restarts the full window.
    task automatic t_shdn_restart();
        @(negedge clk);
        shdn_n = 0; mute_ext = 0; dvdd_ok = 1; pvdd_ok = 1; fault = 0;
        edges(3);
        @(negedge clk); shdn_n = 1;
        edges(N / 2);
        chk("R8", "window running", int_mute, 1'b1);
        @(negedge clk); shdn_n = 0;
        edges(1);
        chk("R8", "int_mute cleared by shutdown", int_mute, 1'b0);
        @(negedge clk); shdn_n = 1;
        edges(N);
        chk("R8", "full window again", int_mute, 1'b1);
        edges(1);
        chk("R8", "window ends on time", int_mute, 1'b0);
        edges(P + 1);
        chk("R8", "enable after restart", stage_en, 1'b1);
        @(negedge clk); shdn_n = 0;
        edges(1);
        chk("R8", "shutdown drops enable", stage_en, 1'b0);
    endtask

    // R9: mute while running is the orderly power-down.
    task automatic t_mute_down();
        bring_up("R3");
        @(negedge clk); mute_ext = 1;
        edges(2);
        chk("R9", "mute drops enable", stage_en, 1'b0);
        @(negedge clk); shdn_n = 0;
        edges(2);
        chk("R9", "stays off in shutdown", stage_en, 1'b0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_early_unmute();
                t_late_unmute();
                t_supply_run();
                t_supply_start();
                t_fault();
                t_shdn_restart();
                t_mute_down();
                chk("R10", "enable and int_mute overlap count", excl_bad != 0, 1'b0);
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule